// File: doc/BRIEF.md
# Two-Destination Handshake Fan-Out Join

This block lets one producer hand each data item to two consumers at once. All three sides use a four-phase request/acknowledge handshake: a "have" line says the data is valid, and a "got" line says it was taken. Everything runs on one shared clock. The producer's "have" and its data go straight to both consumers without any register in between. The two "got" lines that come back are merged into one "got" for the producer.

The merge is not a plain AND of the two acknowledgements. It is a small two-state machine that holds its value. It moves from `MRG_LOW` to `MRG_HIGH` on transition `T_BOTH_UP`, which fires when both consumer "got" lines are high. It moves from `MRG_HIGH` back to `MRG_LOW` on transition `T_BOTH_DOWN`, which fires when both lines are low. In any other case it stays where it is. As a result, the producer sees each edge of its "got" one clock after the slower consumer's edge.

The producer keeps "have" and the data steady until the merged "got" rises. It then drops "have" and waits for the merged "got" to fall before it offers the next item. Each consumer holds its "got" high until "have" goes low. So every control line makes one rising and one falling edge per item.

Top module: `hsj_fanout_join`

## Requirements
- R1: `dn0_have` and `dn1_have` equal `up_have` in the same cycle, with no register on the path.
- R2: `dn0_data` and `dn1_data` equal `up_data` in the same cycle.
- R3: While `rst_n` is low, and after it is released, `up_got` is 0 (state `MRG_LOW`).
- R4: When both `dn0_got` and `dn1_got` are 1 at a rising clock edge, `up_got` is 1 after that edge (transition `T_BOTH_UP`).
- R5: While exactly one of the two destination "got" lines is 1, a low `up_got` stays 0.
- R6: When both `dn0_got` and `dn1_got` are 0 at a rising clock edge, `up_got` is 0 after that edge (transition `T_BOTH_DOWN`).
- R7: While exactly one of the two destination "got" lines is 0, a high `up_got` stays 1.
- R8: If both destinations raise "got" in the same cycle, or lower it in the same cycle, `up_got` changes at the very next edge, exactly as it does when the two edges are staggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_have | input | 1 | Producer data-valid |
| up_data | input | DATA_W | Producer data |
| up_got | output | 1 | Merged acknowledgement to the producer |
| dn0_have | output | 1 | Data-valid to consumer 0 |
| dn0_data | output | DATA_W | Data to consumer 0 |
| dn0_got | input | 1 | Acknowledgement from consumer 0 |
| dn1_have | output | 1 | Data-valid to consumer 1 |
| dn1_data | output | DATA_W | Data to consumer 1 |
| dn1_got | input | 1 | Acknowledgement from consumer 1 |

## Verification
Two events can land in the same cycle: the acknowledgement edge from consumer 0 and the one from consumer 1. The merge has to treat two coincident edges exactly like two staggered ones. A directed task raises both "got" lines on the same falling clock edge, and later lowers them on the same edge. It then checks that `up_got` moves exactly one edge later. A randomized task draws independent delays for each consumer, including equal delays. For every cycle it works out when `up_got` must be high, and it confirms that the data each consumer sees matches the item the producer is still holding.

// File: rtl/hsj_pkg.sv
package hsj_pkg;

    // Merge state: the held value of the joined acknowledgement.
    typedef enum logic {
        MRG_LOW  = 1'b0,
        MRG_HIGH = 1'b1
    } merge_state_t;

    // Number of destinations is fixed by the block's function.
    localparam int unsigned NUM_DEST = 2;

endpackage

// File: rtl/hsj_fanout.sv
module hsj_fanout #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_OUT  = 2
) (
    input  logic                          src_have,
    input  logic [DATA_W-1:0]             src_data,
    output logic [N_OUT-1:0]              out_have,
    output logic [N_OUT-1:0][DATA_W-1:0]  out_data
);

    // Copy valid and data to every destination without a register.
    for (genvar g = 0; g < N_OUT; g++) begin : g_copy
        assign out_have[g] = src_have;
        assign out_data[g] = src_data;
    end

endmodule

// File: rtl/hsj_merge.sv
module hsj_merge
    import hsj_pkg::*;
#(
    parameter int unsigned N_IN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] acks,
    output logic            joined
);

    localparam logic [N_IN-1:0] ALL_ONE = {N_IN{1'b1}};

    merge_state_t state_q;
    merge_state_t state_d;
    logic         all_up;
    logic         all_down;

    assign all_up   = (acks == ALL_ONE);
    assign all_down = (acks == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MRG_LOW:  if (all_up)   state_d = MRG_HIGH;   // T_BOTH_UP
            MRG_HIGH: if (all_down) state_d = MRG_LOW;    // T_BOTH_DOWN
            default:                state_d = MRG_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MRG_LOW;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        joined = (state_q == MRG_HIGH);
    end

    AST_RISE_ON_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        all_up |=> joined); // R4

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!joined && !all_up) |=> !joined); // R5

    AST_FALL_ON_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        all_down |=> !joined); // R6

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && !all_down) |=> joined); // R7

endmodule

// File: rtl/hsj_fanout_join.sv
module hsj_fanout_join
    import hsj_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_have,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_got,
    output logic              dn0_have,
    output logic [DATA_W-1:0] dn0_data,
    input  logic              dn0_got,
    output logic              dn1_have,
    output logic [DATA_W-1:0] dn1_data,
    input  logic              dn1_got
);

    logic [NUM_DEST-1:0]             fan_have;
    logic [NUM_DEST-1:0][DATA_W-1:0] fan_data;
    logic [NUM_DEST-1:0]             ack_vec;

    hsj_fanout #(
        .DATA_W (DATA_W),
        .N_OUT  (NUM_DEST)
    ) u_fanout (
        .src_have (up_have),
        .src_data (up_data),
        .out_have (fan_have),
        .out_data (fan_data)
    );

    assign dn0_have = fan_have[0];
    assign dn1_have = fan_have[1];
    assign dn0_data = fan_data[0];
    assign dn1_data = fan_data[1];
    assign ack_vec  = {dn1_got, dn0_got};

    hsj_merge #(
        .N_IN (NUM_DEST)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .acks   (ack_vec),
        .joined (up_got)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> !up_got); // R3

    AST_ROSE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_got) |-> $past(dn0_got && dn1_got)); // R8

    AST_FELL_NEEDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_got) |-> $past(!dn0_got && !dn1_got)); // R8

endmodule

// File: tb/hsj_fanout_join_tb.sv
module hsj_fanout_join_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_have = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic          up_got;
    logic          dn0_have, dn1_have;
    logic [DW-1:0] dn0_data, dn1_data;
    logic          dn0_got = 1'b0;
    logic          dn1_got = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hsj_fanout_join #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .up_have(up_have), .up_data(up_data), .up_got(up_got),
        .dn0_have(dn0_have), .dn0_data(dn0_data), .dn0_got(dn0_got),
        .dn1_have(dn1_have), .dn1_data(dn1_data), .dn1_got(dn1_got)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R3 reset", {31'd0, up_got}, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R3 after release", {31'd0, up_got}, 32'd0);
    endtask

    task automatic test_forward();
        @(negedge clk);
        up_have = 1'b1; up_data = 16'hA5C3;
        #1;
        check("R1 have0", {31'd0, dn0_have}, 32'd1);
        check("R1 have1", {31'd0, dn1_have}, 32'd1);
        check("R2 data0", {16'd0, dn0_data}, 32'hA5C3);
        check("R2 data1", {16'd0, dn1_data}, 32'hA5C3);
        up_data = 16'h0F0F;
        #1;
        check("R2 data0 change", {16'd0, dn0_data}, 32'h0F0F);
        check("R2 data1 change", {16'd0, dn1_data}, 32'h0F0F);
        up_have = 1'b0;
        #1;
        check("R1 have0 low", {31'd0, dn0_have}, 32'd0);
        check("R1 have1 low", {31'd0, dn1_have}, 32'd0);
    endtask

    // Staggered edges: 'first' selects which destination moves first.
    task automatic test_staggered(input bit first);
        @(negedge clk);
        up_have = 1'b1; up_data = 16'h1234;
        @(negedge clk);
        if (first) dn1_got = 1'b1; else dn0_got = 1'b1;
        tick();
        check("R5 one got high", {31'd0, up_got}, 32'd0);
        tick();
        check("R5 still one got high", {31'd0, up_got}, 32'd0);
        @(negedge clk);
        if (first) dn0_got = 1'b1; else dn1_got = 1'b1;
        tick();
        check("R4 both high", {31'd0, up_got}, 32'd1);
        @(negedge clk);
        up_have = 1'b0;
        if (first) dn1_got = 1'b0; else dn0_got = 1'b0;
        tick();
        check("R7 one got low", {31'd0, up_got}, 32'd1);
        tick();
        check("R7 still one got low", {31'd0, up_got}, 32'd1);
        @(negedge clk);
        if (first) dn0_got = 1'b0; else dn1_got = 1'b0;
        tick();
        check("R6 both low", {31'd0, up_got}, 32'd0);
    endtask

    task automatic test_simultaneous();
        @(negedge clk);
        up_have = 1'b1; up_data = 16'hBEEF;
        @(negedge clk);
        dn0_got = 1'b1; dn1_got = 1'b1;
        #1;
        check("R8 no early rise", {31'd0, up_got}, 32'd0);
        tick();
        check("R8 coincident rise", {31'd0, up_got}, 32'd1);
        @(negedge clk);
        up_have = 1'b0; dn0_got = 1'b0; dn1_got = 1'b0;
        #1;
        check("R8 no early fall", {31'd0, up_got}, 32'd1);
        tick();
        check("R8 coincident fall", {31'd0, up_got}, 32'd0);
    endtask

    // Independent random delays per destination, cycle-exact expectation.
    task automatic test_random(input int items);
        for (int it = 0; it < items; it++) begin
            int d0 = $urandom_range(0, 4);
            int d1 = $urandom_range(0, 4);
            int e0 = $urandom_range(0, 4);
            int e1 = $urandom_range(0, 4);
            int dmax = (d0 > d1) ? d0 : d1;
            int emax = (e0 > e1) ? e0 : e1;
            logic [DW-1:0] val = DW'($urandom);
            @(negedge clk);
            up_have = 1'b1; up_data = val;
            for (int c = 0; c <= dmax; c++) begin
                @(negedge clk);
                dn0_got = (c >= d0);
                dn1_got = (c >= d1);
                check("R2 rnd data0", {16'd0, dn0_data}, {16'd0, val});
                check("R2 rnd data1", {16'd0, dn1_data}, {16'd0, val});
                tick();
                check("R4 R5 rnd rise", {31'd0, up_got}, {31'd0, (c == dmax)});
            end
            @(negedge clk);
            up_have = 1'b0;
            for (int c = 0; c <= emax; c++) begin
                @(negedge clk);
                dn0_got = !(c >= e0);
                dn1_got = !(c >= e1);
                tick();
                check("R6 R7 rnd fall", {31'd0, up_got}, {31'd0, (c != emax)});
            end
        end
    endtask

    initial begin
        test_reset();
        test_forward();
        test_staggered(1'b0);
        test_staggered(1'b1);
        test_simultaneous();
        test_random(40);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule